// File: doc/BRIEF.md
# Sample Capture and Replay Sequencer

This block moves 8-bit audio samples between an external successive-approximation converter, a byte-wide synchronous RAM and an 8-bit DAC holding register. In record mode it launches conversions with a one-cycle strobe, waits for the converter's busy line to fall, and writes each result to consecutive addresses. The strobe that goes with each capture also starts the following conversion, so the converter runs one sample ahead of the stores. In play mode it reads the same region back in order and loads each byte into the DAC register. The converter is not involved.

Software supplies a base address, a sample count, a pacing value and a mode bit, then pulses start. The pacing value adds a programmable number of idle clocks after every sample. Record spends two more fixed cycles per sample than playback, so a region played with the record pace plus two comes out at the rate it was captured. A one-clock done pulse marks the end of every run, including an empty one.

Top module: `sampler_ctrl`

## Requirements
- R1: After reset, done_o, busy_o, adc_conv_o, mem_en_o and mem_we_o are low and dac_o is zero.
- R2: A record run with a nonzero count begins with a single conversion strobe that has no memory access. This is the priming strobe, and it comes in the cycle after start is accepted.
- R3: In record mode the byte on adc_data_i is written only once the synchronized busy input is low. A write is mem_en_o=1 and mem_we_o=1. Writes go to base, base+1, and so on, and their number equals the sample count. A converter that stays busy longer than the pacing delay stalls the capture.
- R4: Every record write cycle also asserts adc_conv_o. A run of N samples therefore issues exactly N+1 strobes.
- R5: With a converter that is ready in time, consecutive record writes are spaced speed+4 clocks apart. A speed of 0 acts as 1.
- R6: In play mode the block reads base, base+1, and so on. A read is mem_en_o=1 and mem_we_o=0. dac_o shows each byte two clocks after its read cycle. Reads are spaced speed+2 clocks apart, and no conversion strobe is issued.
- R7: A start with a sample count of zero gives done_o in the next cycle, with no memory access and no strobe.
- R8: done_o is high for exactly one clock at the end of a run, after which busy_o is low. A start pulse while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| start_i | input | 1 | Begins a run when idle |
| mode_play_i | input | 1 | 1 = play from memory, 0 = record from converter |
| base_addr_i | input | ADDR_W | First address of the region |
| length_i | input | LEN_W | Number of samples |
| speed_i | input | SPEED_W | Idle clocks added per sample (0 behaves as 1) |
| adc_busy_i | input | 1 | Converter busy, asynchronous |
| adc_data_i | input | DATA_W | Converter result |
| adc_conv_o | output | 1 | Conversion start strobe |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_rdata_i | input | DATA_W | RAM read data, valid one clock after a read |
| dac_o | output | DATA_W | DAC holding register |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-clock end-of-run pulse |

## Verification
Recording is tried twice. With a converter that finishes within two clocks, the exact write spacing of speed+4 can be measured. With a converter that stays busy for twenty clocks against a pace of one, any write that ignored busy would store a stale, repeated value. Each converter result is distinct from its neighbours, so a missing priming strobe or a skipped launch shows up as shifted data. Both recordings are played back at different paces to confirm the order and the speed+2 spacing. Zero-length, single-sample and start-while-busy runs cover the edges of the counters and the handshake.

// File: rtl/sampler_pkg.sv
package sampler_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_KICK,
    ST_HOLD,
    ST_PACE,
    ST_WAIT,
    ST_CAP,
    ST_READ,
    ST_LOAD,
    ST_FIN
  } seq_state_t;
endpackage

// File: rtl/sampler_sync.sv
module sampler_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sampler_timer.sv
module sampler_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = (val_i == '0) ? W'(1) : val_i;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q <= W'(1));
endmodule

// File: rtl/sampler_span.sv
module sampler_span #(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] addr_o,
  output logic          empty_o
);
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q;
  logic          upd_en;
  logic [AW-1:0] addr_d;
  logic [LW-1:0] rem_d;

  always_comb begin
    upd_en = load_i | step_i;
    addr_d = addr_q;
    rem_d  = rem_q;
    if (load_i) begin
      addr_d = base_i;
      rem_d  = len_i;
    end else if (step_i) begin
      addr_d = addr_q + AW'(1);
      rem_d  = rem_q - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  assign addr_o  = addr_q;
  assign empty_o = (rem_q == '0);
endmodule

// File: rtl/sampler_ctrl.sv
module sampler_ctrl
  import sampler_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = 16,
  parameter int DATA_W      = 8,
  parameter int SPEED_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               mode_play_i,
  input  logic [ADDR_W-1:0]  base_addr_i,
  input  logic [LEN_W-1:0]   length_i,
  input  logic [SPEED_W-1:0] speed_i,
  input  logic               adc_busy_i,
  input  logic [DATA_W-1:0]  adc_data_i,
  output logic               adc_conv_o,
  output logic               mem_en_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic [DATA_W-1:0]  dac_o,
  output logic               busy_o,
  output logic               done_o
);
  // Settle time after a strobe, so the synchronized busy has caught up.
  localparam logic [SPEED_W-1:0] HOLD_CNT = SPEED_W'(SYNC_STAGES);

  seq_state_t         state_q, state_d;
  logic               mode_q;
  logic [SPEED_W-1:0] speed_q;
  logic [DATA_W-1:0]  dac_q;
  logic               cfg_en, dac_en;
  logic               tmr_load, tmr_exp;
  logic [SPEED_W-1:0] tmr_val;
  logic               span_load, span_step, span_empty;
  logic               busy_s;

  sampler_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (adc_busy_i),
    .sync_o  (busy_s)
  );

  sampler_timer #(.W(SPEED_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .val_i    (tmr_val),
    .expire_o (tmr_exp)
  );

  sampler_span #(.AW(ADDR_W), .LW(LEN_W)) u_span (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (span_load),
    .step_i  (span_step),
    .base_i  (base_addr_i),
    .len_i   (length_i),
    .addr_o  (mem_addr_o),
    .empty_o (span_empty)
  );

  always_comb begin
    state_d   = state_q;
    cfg_en    = 1'b0;
    dac_en    = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = speed_q;
    span_load = 1'b0;
    span_step = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cfg_en    = 1'b1;
          span_load = 1'b1;
          if (length_i == '0)   state_d = ST_FIN;
          else if (mode_play_i) state_d = ST_READ;
          else                  state_d = ST_KICK;
        end
      end
      ST_KICK: begin
        tmr_load = 1'b1;
        tmr_val  = HOLD_CNT;
        state_d  = ST_HOLD;
      end
      ST_HOLD: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          state_d  = ST_PACE;
        end
      end
      ST_PACE: begin
        if (tmr_exp) begin
          if (span_empty)  state_d = ST_FIN;
          else if (mode_q) state_d = ST_READ;
          else             state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!busy_s) state_d = ST_CAP;
      end
      ST_CAP: begin
        span_step = 1'b1;
        tmr_load  = 1'b1;
        tmr_val   = HOLD_CNT;
        state_d   = ST_HOLD;
      end
      ST_READ: state_d = ST_LOAD;
      ST_LOAD: begin
        span_step = 1'b1;
        dac_en    = 1'b1;
        tmr_load  = 1'b1;
        state_d   = ST_PACE;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      speed_q <= '0;
    end else if (cfg_en) begin
      mode_q  <= mode_play_i;
      speed_q <= speed_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dac_q <= '0;
    else if (dac_en) dac_q <= mem_rdata_i;
  end

  assign adc_conv_o  = (state_q == ST_KICK) || (state_q == ST_CAP);
  assign mem_en_o    = (state_q == ST_CAP) || (state_q == ST_READ);
  assign mem_we_o    = (state_q == ST_CAP);
  assign mem_wdata_o = adc_data_i;
  assign dac_o       = dac_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
endmodule

// File: rtl/sampler_ctrl_chk.sv
module sampler_ctrl_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             mode_play_i,
  input logic [LEN_W-1:0] length_i,
  input logic             adc_conv_o,
  input logic             mem_en_o,
  input logic             mem_we_o,
  input logic             busy_o,
  input logic             done_o
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  // R4
  cap_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && mem_we_o) |-> adc_conv_o);

  // R6
  play_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && !mem_we_o) |-> !adc_conv_o);

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && length_i == '0) |=> (done_o && !mem_en_o && !adc_conv_o));

  // R2
  prime_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !mode_play_i && length_i != '0) |=> (adc_conv_o && !mem_en_o));
endmodule

bind sampler_ctrl sampler_ctrl_chk #(.LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .mode_play_i (mode_play_i),
  .length_i    (length_i),
  .adc_conv_o  (adc_conv_o),
  .mem_en_o    (mem_en_o),
  .mem_we_o    (mem_we_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/sim_sampler_ctrl.sv
`timescale 1ns/1ps
module sim_sampler_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        mode_play_i = 1'b0;
  logic [15:0] base_addr_i = '0;
  logic [15:0] length_i = '0;
  logic [7:0]  speed_i = '0;
  logic        adc_busy_i;
  logic [7:0]  adc_data_i;
  logic        adc_conv_o, mem_en_o, mem_we_o, busy_o, done_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i, dac_o;

  always #10 clk = ~clk;

  sampler_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_play_i(mode_play_i),
    .base_addr_i(base_addr_i), .length_i(length_i), .speed_i(speed_i),
    .adc_busy_i(adc_busy_i), .adc_data_i(adc_data_i), .adc_conv_o(adc_conv_o),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .dac_o(dac_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  function automatic logic [7:0] conv_val(input logic [7:0] k);
    return k * 8'd37 + 8'd11;
  endfunction

  // RAM model
  logic [7:0] ram [256];
  always @(posedge clk) begin
    if (mem_en_o) begin
      if (mem_we_o) ram[mem_addr_o[7:0]] <= mem_wdata_o;
      else          mem_rdata_i <= ram[mem_addr_o[7:0]];
    end
  end

  // Converter model: busy rises at the strobe edge, result after conv_len clocks
  int         conv_len = 2;
  int         conv_left;
  logic [7:0] conv_idx;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_busy_i <= 1'b0;
      adc_data_i <= 8'h00;
      conv_left  <= 0;
      conv_idx   <= 8'h00;
    end else if (adc_conv_o) begin
      adc_busy_i <= 1'b1;
      conv_left  <= conv_len;
    end else if (conv_left > 0) begin
      conv_left <= conv_left - 1;
      if (conv_left == 1) begin
        adc_busy_i <= 1'b0;
        adc_data_i <= conv_val(conv_idx);
        conv_idx   <= conv_idx + 8'd1;
      end
    end
  end

  // Scoreboard queues: pushed by the driver, popped by the monitor
  logic [23:0] exp_wr[$];
  logic [15:0] exp_rd[$];
  logic [7:0]  exp_dac[$];
  int          wr_gap = 0;
  int          rd_gap = 0;

  // Monitor
  int       mon_chk = 0, mon_err = 0;
  int       cyc = 0, last_wr = 0, last_rd = 0;
  int       wr_run = 0, rd_run = 0, strobe_run = 0;
  logic [1:0] rd_pipe = 2'b00;
  int       drv_chk = 0, drv_err = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: run hung, got cycle %0d expected < 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", mon_chk + drv_chk + 1, mon_err + drv_err + 1);
      $finish;
    end
    if (rst_n) begin
      if (start_i && !busy_o) begin
        wr_run = 0; rd_run = 0; strobe_run = 0; rd_pipe = 2'b00;
      end
      if (mem_en_o && mem_we_o) begin
        mon_chk++;
        if (exp_wr.size() == 0) begin
          mon_err++;
          $display("FAIL R3: unexpected write addr %h data %h, expected none", mem_addr_o, mem_wdata_o);
        end else begin
          logic [23:0] e;
          e = exp_wr.pop_front();
          if ({mem_addr_o, mem_wdata_o} !== e) begin
            mon_err++;
            $display("FAIL R3: write got %h/%h expected %h/%h", mem_addr_o, mem_wdata_o, e[23:8], e[7:0]);
          end
        end
        mon_chk++;
        if (strobe_run != wr_run + 1) begin
          mon_err++;
          $display("FAIL R2: strobes before write %0d got %0d expected %0d", wr_run, strobe_run, wr_run + 1);
        end
        if (wr_run > 0 && wr_gap != 0) begin
          mon_chk++;
          if (cyc - last_wr != wr_gap) begin
            mon_err++;
            $display("FAIL R5: write spacing got %0d expected %0d", cyc - last_wr, wr_gap);
          end
        end
        last_wr = cyc;
        wr_run++;
      end
      if (rd_pipe[1]) begin
        mon_chk++;
        if (exp_dac.size() == 0) begin
          mon_err++;
          $display("FAIL R6: dac got %h expected no load", dac_o);
        end else begin
          logic [7:0] d;
          d = exp_dac.pop_front();
          if (dac_o !== d) begin
            mon_err++;
            $display("FAIL R6: dac got %h expected %h", dac_o, d);
          end
        end
      end
      rd_pipe = {rd_pipe[0], 1'b0};
      if (mem_en_o && !mem_we_o) begin
        mon_chk++;
        if (exp_rd.size() == 0) begin
          mon_err++;
          $display("FAIL R6: unexpected read addr %h, expected none", mem_addr_o);
        end else begin
          logic [15:0] a;
          a = exp_rd.pop_front();
          if (mem_addr_o !== a) begin
            mon_err++;
            $display("FAIL R6: read addr got %h expected %h", mem_addr_o, a);
          end
        end
        if (rd_run > 0 && rd_gap != 0) begin
          mon_chk++;
          if (cyc - last_rd != rd_gap) begin
            mon_err++;
            $display("FAIL R6: read spacing got %0d expected %0d", cyc - last_rd, rd_gap);
          end
        end
        last_rd = cyc;
        rd_run++;
        rd_pipe[0] = 1'b1;
      end
      if (adc_conv_o) strobe_run++;
    end
  end

  // Driver
  logic [7:0] sref [256];

  task automatic drv_check(input bit ok, input string what, input int got, input int exp);
    drv_chk++;
    if (!ok) begin
      drv_err++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic pulse_start(input bit play, input logic [15:0] base,
                             input logic [15:0] len, input logic [7:0] spd);
    @(posedge clk); #1;
    start_i = 1'b1; mode_play_i = play; base_addr_i = base; length_i = len; speed_i = spd;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
    drv_check(done_o === 1'b1, {tag, " done seen"}, done_o, 1);
    @(negedge clk);
    drv_check(done_o === 1'b0, "R8 done one clock", done_o, 0);
    drv_check(busy_o === 1'b0, "R8 idle after done", busy_o, 0);
  endtask

  task automatic do_record(input logic [15:0] base, input logic [15:0] len,
                           input logic [7:0] spd, input int clen, input bit timed,
                           input bit inject);
    logic [7:0] k0;
    conv_len = clen;
    wr_gap = timed ? (((spd == 0) ? 1 : spd) + 4) : 0;
    @(negedge clk);
    k0 = conv_idx;
    for (int i = 0; i < len; i++) begin
      logic [15:0] a;
      logic [7:0]  v;
      a = base + 16'(i);
      v = conv_val(k0 + 8'(i));
      sref[a[7:0]] = v;
      exp_wr.push_back({a, v});
    end
    pulse_start(1'b0, base, len, spd);
    if (inject) begin
      repeat (4) @(posedge clk);
      #1;
      // R8: a play start while busy must not be taken
      start_i = 1'b1; mode_play_i = 1'b1; base_addr_i = 16'h0010; length_i = 16'd2;
      @(posedge clk); #1;
      start_i = 1'b0;
    end
    wait_done("R3");
    drv_check(exp_wr.size() == 0, "R3 all samples stored", exp_wr.size(), 0);
    drv_check(strobe_run == int'(len) + 1, "R4 strobe count", strobe_run, int'(len) + 1);
  endtask

  task automatic do_play(input logic [15:0] base, input logic [15:0] len, input logic [7:0] spd);
    rd_gap = ((spd == 0) ? 1 : spd) + 2;
    for (int i = 0; i < len; i++) begin
      logic [15:0] a;
      a = base + 16'(i);
      exp_rd.push_back(a);
      exp_dac.push_back(sref[a[7:0]]);
    end
    pulse_start(1'b1, base, len, spd);
    wait_done("R6");
    drv_check(exp_rd.size() == 0, "R6 all reads issued", exp_rd.size(), 0);
    drv_check(exp_dac.size() == 0, "R6 all dac loads", exp_dac.size(), 0);
    drv_check(strobe_run == 0, "R6 no strobe in play", strobe_run, 0);
  endtask

  task automatic do_zero(input bit play);
    @(posedge clk); #1;
    start_i = 1'b1; mode_play_i = play; base_addr_i = 16'h0020; length_i = 16'd0; speed_i = 8'd3;
    @(posedge clk); #1;
    start_i = 1'b0;
    @(negedge clk);
    drv_check(done_o === 1'b1, "R7 done next cycle", done_o, 1);
    @(negedge clk);
    drv_check(done_o === 1'b0, "R8 zero run done one clock", done_o, 0);
    drv_check(wr_run == 0 && rd_run == 0, "R7 no memory access", wr_run + rd_run, 0);
    drv_check(strobe_run == 0, "R7 no strobe", strobe_run, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    drv_check(done_o === 1'b0 && busy_o === 1'b0, "R1 done/busy low", {done_o, busy_o}, 0);
    drv_check(adc_conv_o === 1'b0, "R1 strobe low", adc_conv_o, 0);
    drv_check(mem_en_o === 1'b0 && mem_we_o === 1'b0, "R1 memory idle", {mem_en_o, mem_we_o}, 0);
    drv_check(dac_o === 8'h00, "R1 dac zero", dac_o, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    do_record(16'h0010, 16'd6, 8'd5, 2, 1'b1, 1'b0);   // R5 timed record
    do_play(16'h0010, 16'd6, 8'd7);                     // R6 same rate as record
    do_record(16'h0040, 16'd4, 8'd1, 20, 1'b0, 1'b0);  // R3 slow converter stalls
    do_play(16'h0040, 16'd4, 8'd1);                     // R6 fastest pace
    do_zero(1'b0);                                      // R7 record
    do_zero(1'b1);                                      // R7 play
    do_record(16'h0080, 16'd3, 8'd10, 2, 1'b1, 1'b1);  // R8 start ignored while busy
    do_record(16'h00F0, 16'd1, 8'd0, 2, 1'b0, 1'b0);   // R3 single sample, speed 0
    do_play(16'h00F0, 16'd1, 8'd0);
    do_play(16'h0080, 16'd3, 8'd2);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", mon_chk + drv_chk, mon_err + drv_err);
    $finish;
  end
endmodule